// File: doc/BRIEF.md
# Multiplexed Hex Display Controller

This block drives a four-position seven-segment display in which all positions share one segment bus and only one position is switched on at a time. It keeps a 4-bit value and a decimal-point flag for each position in its own registers. It shows each value as a hexadecimal glyph and steps through the positions at a rate set by a clock divider. The divider ratio is a parameter. Pick it from the system clock frequency so that the full scan repeats fast enough that the eye sees no flicker.

A host updates the values in one of two ways. In word mode, a 16-bit word replaces all four values at once. In nibble mode, a 4-bit mask picks which of four separate nibble inputs are copied. A second mask picks which decimal-point flags are copied from a 4-bit flag input. Both outputs are active low. The segment bus carries segments a to g on bits 0 to 6 and the decimal point on bit 7.

Top module: `hexscan_ctrl`

## Requirements
- R1: While `rst_n` is low, all four values and all decimal-point flags are 0 and position 0 is selected. The outputs are then `dig_sel_n` = 4'b1110 and `seg_n` = 8'hC0.
- R2: With `nib_mode` = 0 and `wr_en` = 1, all four values load from `word_in` on the next clock edge. `word_in[15:12]` goes to position 3, the most significant, and `word_in[3:0]` goes to position 0.
- R3: With `nib_mode` = 0, `wr_en` = 0 and `dp_mask` = 0, no stored value or flag changes.
- R4: With `nib_mode` = 1, position k loads `nib_in[4k+3:4k]` only when `nib_mask[k]` is 1, and `wr_en` has no effect. For example, mask 4'b1001 updates positions 3 and 0 only.
- R5: Each flag k with `dp_mask[k]` = 1 copies `dp_val[k]`. Flags whose mask bit is 0 keep their value. This applies in both modes.
- R6: A nibble or word write and a decimal-point write in the same cycle both take effect.
- R7: Exactly one bit of `dig_sel_n` is low at any time. Bit k low selects position k.
- R8: The selected position advances every `TICK_DIV` clock cycles in the order 0, 1, 2, 3, 0. After reset is released, the first step comes `TICK_DIV` cycles later.
- R9: `seg_n[6:0]` is the active-low glyph of the selected value, using the active-high patterns 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 for 0 to F. `seg_n[7]` is the inverse of the selected position's flag.
- R10: In word mode, `nib_mask` and `nib_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nib_mode | input | 1 | 0: word load, 1: masked per-position load |
| wr_en | input | 1 | Word load strobe (word mode only) |
| word_in | input | 16 | Word for all four positions, position 3 in the top nibble |
| nib_in | input | 16 | Per-position nibbles, position k at bits 4k+3:4k |
| nib_mask | input | 4 | Per-position load mask (nibble mode) |
| dp_val | input | 4 | Decimal-point values, bit k for position k |
| dp_mask | input | 4 | Decimal-point write mask |
| dig_sel_n | output | 4 | Position select, active low |
| seg_n | output | 8 | Segments a-g on bits 0-6, decimal point on bit 7, active low |

## Verification
Directed word loads of distinct digits, read back as the scan visits each position, show whether the word's nibble order matches the position order. Words of four equal nibbles go through all sixteen glyphs. A nibble-mode write with mask 1001 and a flag write with value 1101 and mask 1110, applied on cleared flags, show whether the masking is correct or has been widened to a full load. A flag bit whose value is 1 but whose mask is 0 shows whether the mask is used at all. A word-mode write with a full nibble mask shows that the mask is ignored in that mode. Random cycles mix both modes with simultaneous flag writes and a mid-run reset, and they run across every phase of the scan.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 8;

    // active-high pattern, segment a on bit 0 .. segment g on bit 6
    function automatic logic [6:0] hex_glyph(input logic [NIB_W-1:0] v);
        logic [6:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hexscan_regs.sv
module hexscan_regs
    import hexscan_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nib_mode,
    input  logic                   wr_en,
    input  logic [NDIG*NIB_W-1:0]  word_in,
    input  logic [NDIG*NIB_W-1:0]  nib_in,
    input  logic [NDIG-1:0]        nib_mask,
    input  logic [NDIG-1:0]        dp_val,
    input  logic [NDIG-1:0]        dp_mask,
    output logic [NDIG*NIB_W-1:0]  val_q,
    output logic [NDIG-1:0]        dp_q
);

    localparam int VAL_W = NDIG * NIB_W;

    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic [NDIG-1:0]  dp;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NDIG; k++) begin
            if (!nib_mode && wr_en) begin
                st_d.val[k*NIB_W +: NIB_W] = word_in[k*NIB_W +: NIB_W];
            end else if (nib_mode && nib_mask[k]) begin
                st_d.val[k*NIB_W +: NIB_W] = nib_in[k*NIB_W +: NIB_W];
            end
            if (dp_mask[k]) begin
                st_d.dp[k] = dp_val[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.val;
    assign dp_q  = st_q.dp;

endmodule

// File: rtl/hexscan_scan.sv
module hexscan_scan #(
    parameter int NDIG     = 4,
    parameter int TICK_DIV = 50000,
    localparam int POS_W   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_q
);

    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NDIG - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] pos;
    } scan_t;

    scan_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (sc_q.cnt == CNT_LAST) begin
            sc_d.cnt = '0;
            sc_d.pos = (sc_q.pos == POS_LAST) ? '0 : sc_q.pos + 1'b1;
        end else begin
            sc_d.cnt = sc_q.cnt + 1'b1;
        end
    end

    // divider and position both start from a defined value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign pos_q = sc_q.pos;

endmodule

// File: rtl/hexscan_drive.sv
module hexscan_drive
    import hexscan_pkg::*;
#(
    parameter int NDIG   = 4,
    localparam int POS_W = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic [POS_W-1:0]       pos,
    input  logic [NDIG*NIB_W-1:0]  val,
    input  logic [NDIG-1:0]        dp,
    output logic [NDIG-1:0]        dig_sel_n,
    output logic [SEG_W-1:0]       seg_n
);

    logic [NIB_W-1:0] cur_val;
    logic             cur_dp;

    for (genvar k = 0; k < NDIG; k++) begin : g_sel
        assign dig_sel_n[k] = (pos != POS_W'(k));
    end

    always_comb begin
        cur_val = '0;
        cur_dp  = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
            if (pos == POS_W'(k)) begin
                cur_val = val[k*NIB_W +: NIB_W];
                cur_dp  = dp[k];
            end
        end
        seg_n = ~{cur_dp, hex_glyph(cur_val)};
    end

endmodule

// File: rtl/hexscan_ctrl.sv
module hexscan_ctrl
    import hexscan_pkg::*;
#(
    parameter int NDIG     = 4,
    parameter int TICK_DIV = 50000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nib_mode,
    input  logic                   wr_en,
    input  logic [NDIG*NIB_W-1:0]  word_in,
    input  logic [NDIG*NIB_W-1:0]  nib_in,
    input  logic [NDIG-1:0]        nib_mask,
    input  logic [NDIG-1:0]        dp_val,
    input  logic [NDIG-1:0]        dp_mask,
    output logic [NDIG-1:0]        dig_sel_n,
    output logic [SEG_W-1:0]       seg_n
);

    localparam int POS_W = (NDIG > 1) ? $clog2(NDIG) : 1;

    logic [NDIG*NIB_W-1:0] val_q;
    logic [NDIG-1:0]       dp_q;
    logic [POS_W-1:0]      pos_q;

    hexscan_regs #(.NDIG(NDIG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_mode (nib_mode),
        .wr_en    (wr_en),
        .word_in  (word_in),
        .nib_in   (nib_in),
        .nib_mask (nib_mask),
        .dp_val   (dp_val),
        .dp_mask  (dp_mask),
        .val_q    (val_q),
        .dp_q     (dp_q)
    );

    hexscan_scan #(.NDIG(NDIG), .TICK_DIV(TICK_DIV)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_q (pos_q)
    );

    hexscan_drive #(.NDIG(NDIG)) u_drive (
        .pos       (pos_q),
        .val       (val_q),
        .dp        (dp_q),
        .dig_sel_n (dig_sel_n),
        .seg_n     (seg_n)
    );

endmodule

// File: rtl/hexscan_ctrl_chk.sv
module hexscan_ctrl_chk
    import hexscan_pkg::*;
#(
    parameter int NDIG     = 4,
    parameter int TICK_DIV = 50000
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   nib_mode,
    input logic                   wr_en,
    input logic [NDIG*NIB_W-1:0]  word_in,
    input logic [NDIG*NIB_W-1:0]  nib_in,
    input logic [NDIG-1:0]        nib_mask,
    input logic [NDIG-1:0]        dp_val,
    input logic [NDIG-1:0]        dp_mask,
    input logic [NDIG-1:0]        dig_sel_n,
    input logic [SEG_W-1:0]       seg_n
);

    logic [NDIG-1:0] prev_q;
    logic [31:0]     gap_q;
    logic            armed_q;
    logic            chg;

    assign chg = (dig_sel_n != prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '1;
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q <= dig_sel_n;
            gap_q  <= chg ? 32'd0 : gap_q + 32'd1;
            if (chg) armed_q <= 1'b1;
        end
    end

    p_one_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dig_sel_n) == 1);

    p_scan_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && armed_q) |-> (dig_sel_n == {prev_q[NDIG-2:0], prev_q[NDIG-1]}));

    p_scan_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && armed_q) |-> (gap_q == 32'(TICK_DIV - 1)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nib_mode && !wr_en && dp_mask == '0) |=>
            ($stable(dig_sel_n) -> $stable(seg_n)));

    for (genvar k = 0; k < NDIG; k++) begin : g_pos
        p_word_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!nib_mode && wr_en) |=>
                (!dig_sel_n[k] -> seg_n[6:0] == ~hex_glyph($past(word_in[k*NIB_W +: NIB_W]))));

        p_nib_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (nib_mode && nib_mask[k]) |=>
                (!dig_sel_n[k] -> seg_n[6:0] == ~hex_glyph($past(nib_in[k*NIB_W +: NIB_W]))));

        p_dp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            dp_mask[k] |=> (!dig_sel_n[k] -> seg_n[SEG_W-1] == ~$past(dp_val[k])));
    end

endmodule

bind hexscan_ctrl hexscan_ctrl_chk #(.NDIG(NDIG), .TICK_DIV(TICK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nib_mode  (nib_mode),
    .wr_en     (wr_en),
    .word_in   (word_in),
    .nib_in    (nib_in),
    .nib_mask  (nib_mask),
    .dp_val    (dp_val),
    .dp_mask   (dp_mask),
    .dig_sel_n (dig_sel_n),
    .seg_n     (seg_n)
);

// File: tb/hexscan_ctrl_test.sv
module hexscan_ctrl_test;

    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nib_mode, wr_en;
    logic [15:0] word_in, nib_in;
    logic [3:0]  nib_mask, dp_val, dp_mask;
    logic [3:0]  dig_sel_n;
    logic [7:0]  seg_n;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    hexscan_ctrl #(.NDIG(4), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .wr_en(wr_en),
        .word_in(word_in), .nib_in(nib_in), .nib_mask(nib_mask),
        .dp_val(dp_val), .dp_mask(dp_mask),
        .dig_sel_n(dig_sel_n), .seg_n(seg_n)
    );

    function automatic logic [6:0] ref_glyph(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    // reference state built from the requirements
    logic [3:0] m_val [4];
    logic [3:0] m_dp;
    int         m_cnt, m_pos;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) m_val[k] <= 4'h0;
            m_dp  <= 4'h0;
            m_cnt <= 0;
            m_pos <= 0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (!nib_mode && wr_en) m_val[k] <= word_in[4*k +: 4];
                else if (nib_mode && nib_mask[k]) m_val[k] <= nib_in[4*k +: 4];
                if (dp_mask[k]) m_dp[k] <= dp_val[k];
            end
            if (m_cnt == DIV - 1) begin
                m_cnt <= 0;
                m_pos <= (m_pos + 1) % 4;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(string t, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check("R7/R8 select", {4'h0, dig_sel_n}, {4'h0, ~(4'b0001 << m_pos)});
            check({tag, " segments"}, seg_n, ~{m_dp[m_pos], ref_glyph(m_val[m_pos])});
        end
    end

    task automatic idle_in();
        nib_mode = 1'b0; wr_en = 1'b0; word_in = 16'h0; nib_in = 16'h0;
        nib_mask = 4'h0; dp_val = 4'h0; dp_mask = 4'h0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        idle_in();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1 reset select", {4'h0, dig_sel_n}, 8'h0E);
        check("R1 reset segments", seg_n, 8'hC0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        step(2);

        tag = "R2";
        wr_en = 1'b1; word_in = 16'h1234;
        step(1); step(4 * DIV);

        tag = "R3";
        wr_en = 1'b0; word_in = 16'hFFFF;
        step(1); step(4 * DIV);

        tag = "R10";
        wr_en = 1'b1; word_in = 16'h5678; nib_mask = 4'hF; nib_in = 16'h0000;
        step(1); step(4 * DIV);

        tag = "R4";
        nib_mode = 1'b1; nib_mask = 4'b1001; nib_in = 16'hABCD; wr_en = 1'b0;
        step(1); step(4 * DIV);

        tag = "R5";
        dp_mask = 4'hF; dp_val = 4'h0;
        step(1);
        dp_mask = 4'b1110; dp_val = 4'b1101;
        step(1); step(4 * DIV);

        tag = "R6";
        nib_mode = 1'b1; nib_mask = 4'b0110; nib_in = 16'h0EF0;
        dp_mask = 4'b0011; dp_val = 4'b0011;
        step(1); step(4 * DIV);

        tag = "R9";
        for (int v = 0; v < 16; v++) begin
            wr_en = 1'b1; word_in = {4{v[3:0]}};
            dp_mask = 4'hF; dp_val = v[3:0];
            step(1); step(DIV);
        end

        tag = "R2/R4/R5/R6";
        for (int i = 0; i < 2000; i++) begin
            nib_mode = $urandom_range(0, 1);
            wr_en    = ($urandom_range(0, 3) == 0);
            word_in  = 16'($urandom);
            nib_in   = 16'($urandom);
            nib_mask = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            dp_val   = 4'($urandom);
            dp_mask  = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            @(negedge clk);
        end
        idle_in();

        tag = "R1";
        rst_n = 1'b0;
        step(2);
        check("R1 mid-run reset select", {4'h0, dig_sel_n}, 8'h0E);
        check("R1 mid-run reset segments", seg_n, 8'hC0);
        rst_n = 1'b1;
        step(4 * DIV + 3);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

endmodule